// File: doc/BRIEF.md
# Sensor SPI Command Decoder and Register Bank

This block is the host-facing control port of an image sensor. It acts as an SPI slave in mode 0, MSB first, and takes one byte command at a time. While chip select stays low, the host can send one command after another. A command can start a scan, pulse a soft reset, fetch a status byte, read or write the internal configuration registers, or stream image bytes from a pixel FIFO. Each byte that arrives on MOSI clocks one byte out on MISO. The answer to a read command comes out during the byte after its opcode. The host sends a dummy byte, or its next command, to receive it.

A fast system clock samples the SPI pins. The register bank holds eighteen 8-bit entries, and its contents are available in parallel to the rest of the sensor. A register-write command sets a start address. Every byte after it in the same chip-select window is stored at the next address in turn. A pixel read keeps popping the FIFO for as long as the host sends zero bytes. The first nonzero byte ends the stream and is decoded as a new command.

Top module: `sensor_spi_ctrl`

## Requirements
- R1: After reset, MISO is 0, all eighteen registers read 0x00, and scan_start, soft_rst and fifo_pop are low.
- R2: Transfers use SPI mode 0. MOSI is sampled on the rising SCK edge and MISO changes after the falling edge, MSB first. Every 8 SCK cycles form one byte. The response to an opcode goes out during the next byte, and the first byte of each window returns 0x00.
- R3: Opcode 0x40+N, with N from 0x00 to 0x11, writes the following bytes to registers N, N+1, N+2 and so on until chip select rises. Data bytes are never decoded as commands. Bytes for addresses above 0x11 change nothing. Every byte of a write sequence returns 0x00.
- R4: Opcode 0x20+N, with N from 0x00 to 0x11, returns register N during the next byte.
- R5: Opcode 0x03 returns the value that status_in held when the last bit of the opcode byte was received.
- R6: Opcode 0x01 returns the FIFO head (fifo_data) during the next byte and pulses fifo_pop once. Each later 0x00 byte returns the new head and pops again. The first nonzero byte ends the stream and is decoded as an opcode.
- R7: Opcode 0x02 gives a single-cycle scan_start pulse and returns 0x00.
- R8: Opcode 0xC0 gives a single-cycle soft_rst pulse, returns 0x00 and leaves the registers unchanged.
- R9: Any other opcode byte, including 0x00 outside a pixel stream, 0x32 to 0x3F and 0x52 and above, has no effect, returns 0x00, and leaves the decoder ready for an opcode.
- R10: All commands except register write can be chained within one chip-select window, with each byte acting as both the opcode and the clock for the previous response.
- R11: Raising chip select discards a partial byte and returns the decoder to the opcode state. A few clocks later, MISO reads 0.
- R12: At most one of scan_start, soft_rst and fifo_pop is high in any cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | Serial data from the host |
| spi_csn | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to the host |
| fifo_data | input | 8 | Head byte of the pixel FIFO (show-ahead) |
| fifo_pop | output | 1 | One-cycle request to advance the FIFO |
| status_in | input | 8 | Live status byte |
| scan_start | output | 1 | One-cycle scan start pulse |
| soft_rst | output | 1 | One-cycle soft reset pulse |
| regs_flat | output | 144 | Register contents, register k in bits [8k+7:8k] |

## Verification
The hardest case to reach from the ports is a chip-select rise in the middle of a byte. The block must discard the partial byte, so the next window's bits are not appended to stale bits. The bench sends five bits of a write opcode and then deselects. It then opens a new window with a register read, so any leftover bit count would turn that read into a write and corrupt both MISO and the register bank. The write-stream case needs similar care. Data bytes are chosen to look like read opcodes, and the register they point at is preloaded with a nonzero value, so any byte that is wrongly decoded as a command shows up as a nonzero MISO byte.

// File: rtl/sspi_pkg.sv
package sspi_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_PIXEL   = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_START   = 8'h02;
  localparam logic [BYTE_W-1:0] OPC_STATUS  = 8'h03;
  localparam logic [BYTE_W-1:0] OPC_SRST    = 8'hC0;
  localparam logic [BYTE_W-1:0] OPC_RD_BASE = 8'h20;
  localparam logic [BYTE_W-1:0] OPC_WR_BASE = 8'h40;
  localparam logic [BYTE_W-1:0] OPC_NOP     = 8'h00;

  typedef enum logic [1:0] {
    ST_OPCODE = 2'd0,
    ST_STREAM = 2'd1,
    ST_WRITE  = 2'd2
  } dec_state_e;
endpackage

// File: rtl/sspi_sync.sv
module sspi_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic csn,
  output logic rst_n_int,
  output logic mosi_s,
  output logic cs_active,
  output logic sck_rise,
  output logic sck_fall
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] PIN_RST = 3'b100;

  logic [1:0]      rst_pipe;
  logic [NPIN-1:0] pins_raw;
  logic [NPIN-1:0] pins_s;
  logic            sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  assign pins_raw = {csn, mosi, sck};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] stg;
    always_ff @(posedge clk or negedge rst_n_int) begin
      if (!rst_n_int) stg <= {SYNC_STAGES{PIN_RST[p]}};
      else            stg <= {stg[SYNC_STAGES-2:0], pins_raw[p]};
    end
    assign pins_s[p] = stg[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) sck_prev <= 1'b0;
    else            sck_prev <= pins_s[0];
  end

  assign cs_active = ~pins_s[2];
  assign mosi_s    = pins_s[1];
  assign sck_rise  = cs_active &  pins_s[0] & ~sck_prev;
  assign sck_fall  = cs_active & ~pins_s[0] &  sck_prev;
endmodule

// File: rtl/sspi_shifter.sv
module sspi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_active,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  input  logic [DW-1:0] load_byte,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte,
  output logic          miso
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] rx_q, rx_n;
  logic [DW-1:0] tx_q, tx_n;

  assign byte_done = sck_rise && (cnt_q == LAST);
  assign rx_byte   = {rx_q[DW-2:0], mosi_s};
  assign miso      = tx_q[DW-1];

  always_comb begin
    cnt_n = cnt_q;
    rx_n  = rx_q;
    tx_n  = tx_q;
    if (!cs_active) begin
      cnt_n = '0;
      rx_n  = '0;
      tx_n  = '0;
    end else begin
      if (sck_rise) begin
        rx_n  = rx_byte;
        cnt_n = (cnt_q == LAST) ? '0 : CW'(cnt_q + 1'b1);
      end
      if (byte_done)
        tx_n = load_byte;
      else if (sck_fall && (cnt_q != '0))
        tx_n = {tx_q[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      rx_q  <= rx_n;
      tx_q  <= tx_n;
    end
  end
endmodule

// File: rtl/sspi_decoder.sv
module sspi_decoder
  import sspi_pkg::*;
#(
  parameter int NUM_REGS = 18,
  parameter int AW = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic [BYTE_W-1:0] status_in,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [AW-1:0]     rd_addr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              fifo_pop,
  output logic              scan_start,
  output logic              soft_rst
);
  localparam int PW = $clog2(NUM_REGS + 1);
  localparam logic [PW-1:0]     PTR_END = PW'(NUM_REGS);
  localparam logic [BYTE_W-1:0] RD_END  = BYTE_W'(OPC_RD_BASE + NUM_REGS);
  localparam logic [BYTE_W-1:0] WR_END  = BYTE_W'(OPC_WR_BASE + NUM_REGS);

  dec_state_e    st_q, st_n;
  logic [PW-1:0] ptr_q, ptr_n;
  logic          pop_q, pop_n;
  logic          scan_q, scan_n;
  logic          srst_q, srst_n;
  logic          is_rd, is_wr;
  logic          stream_more;

  assign is_rd = (rx_byte >= OPC_RD_BASE) && (rx_byte < RD_END);
  assign is_wr = (rx_byte >= OPC_WR_BASE) && (rx_byte < WR_END);
  assign stream_more = (st_q == ST_STREAM) && (rx_byte == OPC_NOP);

  assign rd_addr = AW'(rx_byte - OPC_RD_BASE);
  assign wr_addr = ptr_q[AW-1:0];
  assign wr_data = rx_byte;

  always_comb begin
    st_n    = st_q;
    ptr_n   = ptr_q;
    pop_n   = 1'b0;
    scan_n  = 1'b0;
    srst_n  = 1'b0;
    tx_byte = '0;
    wr_en   = 1'b0;
    if (!cs_active) begin
      st_n = ST_OPCODE;
    end else if (byte_done) begin
      if (st_q == ST_WRITE) begin
        if (ptr_q < PTR_END) begin
          wr_en = 1'b1;
          ptr_n = PW'(ptr_q + 1'b1);
        end
      end else if (stream_more) begin
        tx_byte = fifo_data;
        pop_n   = 1'b1;
      end else begin
        st_n = ST_OPCODE;
        if (rx_byte == OPC_PIXEL) begin
          tx_byte = fifo_data;
          pop_n   = 1'b1;
          st_n    = ST_STREAM;
        end else if (rx_byte == OPC_START) begin
          scan_n = 1'b1;
        end else if (rx_byte == OPC_STATUS) begin
          tx_byte = status_in;
        end else if (rx_byte == OPC_SRST) begin
          srst_n = 1'b1;
        end else if (is_rd) begin
          tx_byte = rd_data;
        end else if (is_wr) begin
          st_n  = ST_WRITE;
          ptr_n = PW'(rx_byte - OPC_WR_BASE);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OPCODE;
      ptr_q  <= '0;
      pop_q  <= 1'b0;
      scan_q <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      ptr_q  <= ptr_n;
      pop_q  <= pop_n;
      scan_q <= scan_n;
      srst_q <= srst_n;
    end
  end

  assign fifo_pop   = pop_q;
  assign scan_start = scan_q;
  assign soft_rst   = srst_q;
endmodule

// File: rtl/sspi_regfile.sv
module sspi_regfile #(
  parameter int NUM_REGS = 18,
  parameter int DW = 8,
  parameter int AW = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_data,
  output logic [NUM_REGS*DW-1:0] regs_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic          sel;
    logic [DW-1:0] val_q;
    assign sel = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (sel) val_q <= wr_data;
    end
    assign regs_flat[i*DW +: DW] = val_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == AW'(i)) rd_data = regs_flat[i*DW +: DW];
    end
  end
endmodule

// File: rtl/sensor_spi_ctrl.sv
module sensor_spi_ctrl
  import sspi_pkg::*;
#(
  parameter int NUM_REGS    = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sck,
  input  logic                       spi_mosi,
  input  logic                       spi_csn,
  output logic                       spi_miso,
  input  logic [BYTE_W-1:0]          fifo_data,
  output logic                       fifo_pop,
  input  logic [BYTE_W-1:0]          status_in,
  output logic                       scan_start,
  output logic                       soft_rst,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  localparam int AW = $clog2(NUM_REGS);

  logic              rst_n_int, mosi_s, cs_active, sck_rise, sck_fall;
  logic              byte_done, wr_en;
  logic [BYTE_W-1:0] rx_byte, tx_byte, rd_data, wr_data;
  logic [AW-1:0]     rd_addr, wr_addr;

  sspi_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .mosi(spi_mosi), .csn(spi_csn),
    .rst_n_int(rst_n_int), .mosi_s(mosi_s), .cs_active(cs_active),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  sspi_shifter #(.DW(BYTE_W)) shift_i (
    .clk(clk), .rst_n(rst_n_int), .cs_active(cs_active),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .load_byte(tx_byte), .byte_done(byte_done), .rx_byte(rx_byte),
    .miso(spi_miso)
  );

  sspi_decoder #(.NUM_REGS(NUM_REGS), .AW(AW)) dec_i (
    .clk(clk), .rst_n(rst_n_int), .cs_active(cs_active),
    .byte_done(byte_done), .rx_byte(rx_byte), .fifo_data(fifo_data),
    .status_in(status_in), .rd_data(rd_data), .tx_byte(tx_byte),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fifo_pop(fifo_pop), .scan_start(scan_start), .soft_rst(soft_rst)
  );

  sspi_regfile #(.NUM_REGS(NUM_REGS), .DW(BYTE_W), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .regs_flat(regs_flat)
  );
endmodule

// File: rtl/sensor_spi_ctrl_chk.sv
module sensor_spi_ctrl_chk #(
  parameter int NUM_REGS    = 18,
  parameter int SYNC_STAGES = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  spi_csn,
  input logic                  spi_miso,
  input logic                  scan_start,
  input logic                  soft_rst,
  input logic                  fifo_pop,
  input logic [NUM_REGS*8-1:0] regs_flat
);
  localparam int SETTLE = SYNC_STAGES + 4;
  localparam logic [4:0] SETTLE_V = 5'(SETTLE);

  logic [4:0] idle_cnt;
  logic       idle_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (!spi_csn)          idle_cnt <= '0;
    else if (idle_cnt != 5'h1F) idle_cnt <= idle_cnt + 5'd1;
  end
  assign idle_ok = idle_cnt >= SETTLE_V;

  AST_MISO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ok |-> !spi_miso);                                          // R11
  AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ok |-> !(scan_start || soft_rst || fifo_pop));              // R11
  AST_REGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt > SETTLE_V) |-> $stable(regs_flat));                   // R3
  AST_SCAN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |=> !scan_start);                                     // R7
  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);                                         // R8
  AST_POP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);                                         // R6
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scan_start, soft_rst, fifo_pop}));                     // R12
endmodule

bind sensor_spi_ctrl sensor_spi_ctrl_chk #(
  .NUM_REGS(NUM_REGS), .SYNC_STAGES(SYNC_STAGES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_miso(spi_miso),
  .scan_start(scan_start), .soft_rst(soft_rst), .fifo_pop(fifo_pop),
  .regs_flat(regs_flat)
);

// File: tb/sensor_spi_ctrl_tb_top.sv
`timescale 1ns/1ps
module sensor_spi_ctrl_tb_top;
  localparam int NREG = 18;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_mosi = 1'b0, spi_csn = 1'b1;
  logic spi_miso, fifo_pop, scan_start, soft_rst;
  logic [7:0] fifo_data, status_in = 8'h00;
  logic [NREG*8-1:0] regs_flat;

  int checks = 0, errors = 0;
  int scan_cnt = 0, srst_cnt = 0, pop_cnt = 0;
  logic [7:0] fifo_idx = 8'd0;
  logic [7:0] exp_regs [NREG];

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  sensor_spi_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_csn(spi_csn), .spi_miso(spi_miso), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .status_in(status_in), .scan_start(scan_start),
    .soft_rst(soft_rst), .regs_flat(regs_flat)
  );

  assign fifo_data = 8'hA0 + fifo_idx;

  always @(posedge clk) begin
    if (fifo_pop)   begin pop_cnt++; fifo_idx <= fifo_idx + 8'd1; end
    if (scan_start) scan_cnt++;
    if (soft_rst)   srst_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: assembles MISO bytes as a mode-0 host would and scores them.
  int         mon_bits = 0;
  logic [7:0] mon_byte = 8'h00;
  always @(posedge spi_sck or posedge spi_csn) begin
    if (spi_csn) begin
      mon_bits = 0;
    end else begin
      mon_byte = {mon_byte[6:0], spi_miso};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (exp_q.size() == 0) begin
          check("R2 unexpected byte", 32'(mon_byte), 32'hFFFF);
        end else begin
          check(tag_q.pop_front(), 32'(mon_byte), 32'(exp_q.pop_front()));
        end
      end
    end
  end

  task automatic cs_low();
    @(negedge clk);
    spi_csn = 1'b0;
    #(HALF);
  endtask

  task automatic cs_high();
    #(HALF);
    spi_csn = 1'b1;
    #(3*HALF);
  endtask

  task automatic send_bits(input logic [7:0] val, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = val[i];
      #(HALF) spi_sck = 1'b1;
      #(HALF) spi_sck = 1'b0;
    end
  endtask

  // Driver: pushes the expected MISO byte, then clocks the byte out.
  task automatic xfer(input logic [7:0] val, input logic [7:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    send_bits(val, 8);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      check(req, 32'(regs_flat[i*8 +: 8]), 32'(exp_regs[i]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    // R1 reset state
    check("R1 miso", 32'(spi_miso), 0);
    check("R1 pulses", 32'({scan_start, soft_rst, fifo_pop}), 0);
    check_regs("R1 regs");

    // R3 write stream from address 0
    cs_low();
    xfer(8'h40, 8'h00, "R2 first byte");
    xfer(8'h11, 8'h00, "R3 data");
    xfer(8'h22, 8'h00, "R3 data");
    xfer(8'h33, 8'h00, "R3 data");
    xfer(8'h44, 8'h00, "R3 data");
    cs_high();
    exp_regs[0] = 8'h11; exp_regs[1] = 8'h22; exp_regs[2] = 8'h33; exp_regs[3] = 8'h44;
    check_regs("R3 stream");

    // R3 data resembling a read opcode must be stored, not decoded
    cs_low();
    xfer(8'h4F, 8'h00, "R3 opcode");
    xfer(8'h23, 8'h00, "R3 data not decoded");
    xfer(8'h00, 8'h00, "R3 data not decoded");
    cs_high();
    exp_regs[15] = 8'h23; exp_regs[16] = 8'h00;
    check_regs("R3 consumed window");

    // R3 writes past the last address are ignored
    cs_low();
    xfer(8'h50, 8'h00, "R3 opcode");
    xfer(8'hAA, 8'h00, "R3 data");
    xfer(8'hBB, 8'h00, "R3 data");
    xfer(8'hCC, 8'h00, "R3 beyond end");
    xfer(8'hDD, 8'h00, "R3 beyond end");
    cs_high();
    exp_regs[16] = 8'hAA; exp_regs[17] = 8'hBB;
    check_regs("R3 end clip");

    // R4 R10 chained register reads
    cs_low();
    xfer(8'h20, 8'h00, "R2 first byte");
    xfer(8'h21, 8'h11, "R4 reg0");
    xfer(8'h22, 8'h22, "R4 reg1 R10");
    xfer(8'h31, 8'h33, "R4 reg2 R10");
    xfer(8'h00, 8'hBB, "R4 reg17");
    cs_high();

    // R5 status is captured at the end of the opcode byte
    status_in = 8'h5A;
    cs_low();
    xfer(8'h03, 8'h00, "R5 opcode");
    status_in = 8'h00;
    xfer(8'h00, 8'h5A, "R5 status");
    cs_high();

    // R6 pixel streaming ended by a nonzero opcode
    cs_low();
    xfer(8'h01, 8'h00, "R6 opcode");
    xfer(8'h00, 8'hA0, "R6 pixel0");
    xfer(8'h00, 8'hA1, "R6 pixel1");
    xfer(8'h00, 8'hA2, "R6 pixel2");
    xfer(8'h21, 8'hA3, "R6 pixel3");
    xfer(8'h00, 8'h22, "R6 R10 read after stream");
    cs_high();
    check("R6 pop count", 32'(pop_cnt), 4);

    // R7 scan start
    cs_low();
    xfer(8'h02, 8'h00, "R7 opcode");
    xfer(8'h00, 8'h00, "R7 response");
    cs_high();
    check("R7 scan pulses", 32'(scan_cnt), 1);

    // R8 soft reset keeps registers
    cs_low();
    xfer(8'hC0, 8'h00, "R8 opcode");
    xfer(8'h20, 8'h00, "R8 response");
    xfer(8'h00, 8'h11, "R8 R10 reg0 kept");
    cs_high();
    check("R8 soft pulses", 32'(srst_cnt), 1);
    check_regs("R8 regs kept");

    // R9 undefined opcodes
    cs_low();
    xfer(8'h35, 8'h00, "R9 first");
    xfer(8'h7F, 8'h00, "R9 undef 0x35");
    xfer(8'h52, 8'h00, "R9 undef 0x7F");
    xfer(8'h00, 8'h00, "R9 undef 0x52");
    xfer(8'h21, 8'h00, "R9 undef 0x00");
    xfer(8'h00, 8'h22, "R9 decoder ready");
    cs_high();
    check_regs("R9 regs unchanged");
    check("R9 pulses", 32'(scan_cnt + srst_cnt), 2);
    check("R9 pops", 32'(pop_cnt), 4);

    // R11 partial byte aborted by chip select
    cs_low();
    send_bits(8'h40, 5);
    cs_high();
    check("R11 miso idle", 32'(spi_miso), 0);
    cs_low();
    xfer(8'h21, 8'h00, "R11 fresh byte");
    xfer(8'h00, 8'h22, "R11 read reg1");
    cs_high();
    check_regs("R11 regs");
    check("R12 pops total", 32'(pop_cnt), 4);

    check("R2 all bytes seen", 32'(exp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule